// File: doc/BRIEF.md
# Reset Sequencer with Cause Register

This block turns several reset requests into one fixed release schedule for a processor subsystem. Its requests are a power-on pulse, a watchdog overflow strobe, a low-voltage strobe and the sensed level of the shared active-low reset pin. It drives that pin low in open-drain fashion and gates the module clocks during oscillator start-up. It holds the processor in reset until the schedule ends. It also records which request caused the most recent reset. Every counter runs on the crystal clock. The power-on pulse initialises all state asynchronously, and all outputs are released on clock edges.

A power-on pulse begins a 4096-cycle stabilisation phase. During this phase the clocks are gated off and the pin is held low. A 32-cycle pin-drive phase follows, then a 32-cycle hold phase in which the pin is released but the processor is still held. A watchdog or low-voltage strobe skips stabilisation and starts directly at the pin-drive phase. When an outside device pulls the pin low, the block holds the processor for as long as the pin stays low, then adds the 32-cycle hold phase. A new request arriving during a sequence restarts it for that request. The power-on pulse overrides everything.

The cause register is read-only. It is loaded with the collected cause bits on the clock edge that releases the processor, and it does not change at any other time. A parameter selects whether a non-power-on reset clears the other cause bits (the default) or keeps them.

Top module: `rstseq_top`

## Requirements
- R1: After the power-on pulse falls, `clk_gate_en` is low and `rst_pin_drive` is high for exactly STAB_CYC (4096) clock cycles. Once `clk_gate_en` goes high, it stays high until the next power-on pulse.
- R2: After a power-on, `rst_pin_drive` stays high for a further DRIVE_CYC (32) cycles after stabilisation ends, giving 4128 cycles in total.
- R3: After a power-on, `cpu_hold` stays high for DRIVE_CYC+HOLD_CYC (64) cycles after stabilisation ends, giving 4160 cycles in total. The processor is never released in the same cycle that the pin drive ends.
- R4: `cause_status` reads 0 from the power-on pulse until the first release. From that release it reads 4'b0011: bit 0 (power-on) and bit 1 (low voltage) set, all other bits clear.
- R5: A `wdog_ovf` strobe seen on a clock edge drives the pin low for the next 32 cycles and holds the processor for 64 cycles. At release, bit 2 of `cause_status` is set.
- R6: A `lowv_trip` strobe produces the same 32/64-cycle schedule as R5. At release, bit 1 of `cause_status` is set.
- R7: The sensed pin level `rst_pin_n_in` passes through SYNC_STAGES (2) flops. When it is low while the processor is running, `cpu_hold` is raised and `rst_pin_drive` stays low. After the pin returns high, the hold lasts SYNC_STAGES+1+HOLD_CYC (35) sampled cycles. At release, bit 3 of `cause_status` is set.
- R8: A watchdog or low-voltage strobe during a pin-drive, hold or external-wait phase restarts the schedule with a full 32-cycle drive and 64-cycle hold, counted from that strobe.
- R9: Watchdog and low-voltage strobes during stabilisation are ignored. A low pin level is ignored outside the running state, so the block's own drive never reads back as an external reset.
- R10: `cause_status` changes only on the clock edge where `cpu_hold` falls.
- R11: With CLEAR_OTHERS=1, a non-power-on reset leaves only its own cause bits set. With CLEAR_OTHERS=0, the new bits are ORed into the bits already collected, starting from 4'b0011 after power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-derived clock for all counters |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous initialisation |
| wdog_ovf | input | 1 | Watchdog counter overflow strobe |
| lowv_trip | input | 1 | Low-voltage detection strobe |
| rst_pin_n_in | input | 1 | Sensed level of the shared active-low reset pin |
| rst_pin_drive | output | 1 | 1 pulls the reset pin low (open-drain enable) |
| clk_gate_en | output | 1 | 1 lets clocks reach the processor and modules |
| cpu_hold | output | 1 | 1 holds the processor in reset |
| cause_status | output | 4 | Cause register: bit0 power-on, bit1 low voltage, bit2 watchdog, bit3 external pin |

## Verification
The assertions assume the power-on pulse is long enough to be seen at least once by the asynchronous reset. They also assume the pin input follows the open-drain sum of the block's own drive and any outside pull. Under that assumption, an active drive is always observed as a low pin, and the checks that the pin and processor holds are nested remain valid. The bench models the pin as that wired-AND and changes every input half a cycle away from the active edge. Strobes are one cycle long and are placed so that each phase boundary is measured by counting sampled cycles.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  localparam int NCAUSE = 4;

  localparam int C_POWERON = 0;
  localparam int C_LOWV    = 1;
  localparam int C_WDOG    = 2;
  localparam int C_PIN     = 3;

  typedef enum logic [2:0] {
    ST_STAB = 3'd0,
    ST_DRIVE = 3'd1,
    ST_HOLD = 3'd2,
    ST_EXTW = 3'd3,
    ST_RUN = 3'd4
  } seq_state_t;

  typedef logic [NCAUSE-1:0] cause_vec_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain_q[g] <= 1'b1;
          else      chain_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain_q[g] <= 1'b1;
          else      chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int STAB_CYC  = 4096,
  parameter int DRIVE_CYC = 32,
  parameter int HOLD_CYC  = 32
) (
  input  logic       clk,
  input  logic       arst,
  input  logic       wdog_req,
  input  logic       lowv_req,
  input  logic       pin_low,
  output seq_state_t state_o,
  output cause_vec_t trig_o,
  output logic       done_o
);

  localparam int MAXC = (STAB_CYC > DRIVE_CYC) ?
                        ((STAB_CYC > HOLD_CYC) ? STAB_CYC : HOLD_CYC) :
                        ((DRIVE_CYC > HOLD_CYC) ? DRIVE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STAB_LAST  = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] DRIVE_LAST = CW'(DRIVE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  seq_state_t      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            take_int, take_ext;

  assign take_int = (wdog_req | lowv_req) && (state_q != ST_STAB);
  assign take_ext = pin_low && (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    if (take_int) begin
      state_d = ST_DRIVE;
      cnt_d   = '0;
    end else if (take_ext) begin
      state_d = ST_EXTW;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_STAB: if (cnt_q == STAB_LAST) begin
          state_d = ST_DRIVE;
          cnt_d   = '0;
        end
        ST_DRIVE: if (cnt_q == DRIVE_LAST) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end
        ST_HOLD: if (cnt_q == HOLD_LAST) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
        ST_EXTW: begin
          cnt_d = '0;
          if (!pin_low) state_d = ST_HOLD;
        end
        ST_RUN: cnt_d = '0;
        default: begin
          state_d = ST_STAB;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      state_q <= ST_STAB;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    trig_o = '0;
    if (take_int) begin
      trig_o[C_WDOG] = wdog_req;
      trig_o[C_LOWV] = lowv_req;
    end else if (take_ext) begin
      trig_o[C_PIN] = 1'b1;
    end
  end

  assign done_o  = !take_int && (state_q == ST_HOLD) && (cnt_q == HOLD_LAST);
  assign state_o = state_q;

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
  import rstseq_pkg::*;
#(
  parameter bit CLEAR_OTHERS = 1'b1
) (
  input  logic       clk,
  input  logic       arst,
  input  cause_vec_t trig,
  input  logic       done,
  output cause_vec_t status_o
);

  localparam cause_vec_t POR_CAUSE = cause_vec_t'((1 << C_POWERON) | (1 << C_LOWV));

  cause_vec_t collect_q, status_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      collect_q <= POR_CAUSE;
    end else if (trig != '0) begin
      if (CLEAR_OTHERS) collect_q <= trig;
      else              collect_q <= collect_q | trig;
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      status_q <= '0;
    else if (done) status_q <= collect_q;
  end

  assign status_o = status_q;

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int STAB_CYC     = 4096,
  parameter int DRIVE_CYC    = 32,
  parameter int HOLD_CYC     = 32,
  parameter int SYNC_STAGES  = 2,
  parameter bit CLEAR_OTHERS = 1'b1
) (
  input  logic                clk_xtal,
  input  logic                por_pulse,
  input  logic                wdog_ovf,
  input  logic                lowv_trip,
  input  logic                rst_pin_n_in,
  output logic                rst_pin_drive,
  output logic                clk_gate_en,
  output logic                cpu_hold,
  output logic [NCAUSE-1:0]   cause_status
);

  logic       pin_n_sync;
  seq_state_t state;
  cause_vec_t trig;
  logic       done;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_xtal),
    .arst  (por_pulse),
    .d_in  (rst_pin_n_in),
    .q_out (pin_n_sync)
  );

  rstseq_ctrl #(
    .STAB_CYC  (STAB_CYC),
    .DRIVE_CYC (DRIVE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk      (clk_xtal),
    .arst     (por_pulse),
    .wdog_req (wdog_ovf),
    .lowv_req (lowv_trip),
    .pin_low  (!pin_n_sync),
    .state_o  (state),
    .trig_o   (trig),
    .done_o   (done)
  );

  rstseq_status #(.CLEAR_OTHERS(CLEAR_OTHERS)) u_status (
    .clk      (clk_xtal),
    .arst     (por_pulse),
    .trig     (trig),
    .done     (done),
    .status_o (cause_status)
  );

  assign rst_pin_drive = (state == ST_STAB) || (state == ST_DRIVE);
  assign clk_gate_en   = (state != ST_STAB);
  assign cpu_hold      = (state != ST_RUN);

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       por,
  input logic       pin_drive,
  input logic       gate_en,
  input logic       hold,
  input logic [3:0] status
);

  // R2: pin drive lies inside the processor hold window
  a_r2_pin_in_hold: assert property (@(posedge clk) disable iff (por)
    pin_drive |-> hold);

  // R1: clocks gated only while the pin is driven
  a_r1_gate_in_pin: assert property (@(posedge clk) disable iff (por)
    !gate_en |-> pin_drive);

  // R1: gating never returns without a power-on pulse
  a_r1_gate_sticky: assert property (@(posedge clk) disable iff (por)
    gate_en |=> gate_en);

  // R3: release never straight out of the drive phase
  a_r3_release_after_pin: assert property (@(posedge clk) disable iff (por)
    $fell(hold) |-> !$past(pin_drive));

  // R10: cause register moves only at release
  a_r10_status_stable: assert property (@(posedge clk) disable iff (por)
    !$fell(hold) |-> $stable(status));

  // R4: power-on cause always reported with low-voltage cause
  a_r4_por_with_lowv: assert property (@(posedge clk) disable iff (por)
    status[0] |-> status[1]);

endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk       (clk_xtal),
  .por       (por_pulse),
  .pin_drive (rst_pin_drive),
  .gate_en   (clk_gate_en),
  .hold      (cpu_hold),
  .status    (cause_status)
);

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;

  logic clk = 1'b0;
  logic por_pulse = 1'b1;
  logic wdog_ovf = 1'b0;
  logic lowv_trip = 1'b0;
  logic ext_pull = 1'b0;
  logic pin_n;
  logic drv0, drv1, gate0, gate1, hold0, hold1;
  logic [3:0] st0, st1;
  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  assign pin_n = !(drv0 | drv1 | ext_pull);

  rstseq_top u0 (
    .clk_xtal(clk), .por_pulse(por_pulse), .wdog_ovf(wdog_ovf),
    .lowv_trip(lowv_trip), .rst_pin_n_in(pin_n), .rst_pin_drive(drv0),
    .clk_gate_en(gate0), .cpu_hold(hold0), .cause_status(st0)
  );

  rstseq_top #(.CLEAR_OTHERS(1'b0)) u1 (
    .clk_xtal(clk), .por_pulse(por_pulse), .wdog_ovf(wdog_ovf),
    .lowv_trip(lowv_trip), .rst_pin_n_in(pin_n), .rst_pin_drive(drv1),
    .clk_gate_en(gate1), .cpu_hold(hold1), .cause_status(st1)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count sampled cycles, starting at the current negedge, until release
  task automatic observe(output int n_gate_off, output int n_pin, output int n_hold);
    n_gate_off = 0; n_pin = 0; n_hold = 0;
    for (int i = 0; i < 6000; i++) begin
      if (!hold0) break;
      if (!gate0) n_gate_off++;
      if (drv0) n_pin++;
      n_hold++;
      @(negedge clk);
    end
  endtask

  task automatic t_poweron;
    int g, p, h;
    @(negedge clk);
    check("R4 reset status", st0, 0);
    check("R1 reset gate", gate0, 0);
    por_pulse = 1'b0;
    fork
      begin
        repeat (100) @(negedge clk);
        wdog_ovf = 1'b1;   // R9: ignored during stabilisation
        @(negedge clk);
        wdog_ovf = 1'b0;
        repeat (50) @(negedge clk);
        lowv_trip = 1'b1;
        @(negedge clk);
        lowv_trip = 1'b0;
      end
      observe(g, p, h);
    join
    check("R1 gate-off cycles", g, 4096);
    check("R2 pin cycles", p, 4128);
    check("R3 hold cycles", h, 4160);
    check("R4 status u0", st0, 4'b0011);
    check("R4 status u1", st1, 4'b0011);
    check("R9 stab strobe ignored gate", gate0, 1);
  endtask

  task automatic t_wdog;
    int g, p, h;
    repeat (5) @(negedge clk);
    wdog_ovf = 1'b1;
    @(negedge clk);
    wdog_ovf = 1'b0;
    check("R10 status held during seq", st0, 4'b0011);
    observe(g, p, h);
    check("R5 pin cycles", p, 32);
    check("R5 hold cycles", h, 64);
    check("R5 gate stays on", g, 0);
    check("R5 R11 status u0 clear", st0, 4'b0100);
    check("R11 status u1 accumulate", st1, 4'b0111);
  endtask

  task automatic t_restart;
    int g, p, h;
    repeat (5) @(negedge clk);
    wdog_ovf = 1'b1;
    @(negedge clk);
    wdog_ovf = 1'b0;
    repeat (40) @(negedge clk);   // inside hold phase
    check("R10 status mid hold", st0, 4'b0100);
    lowv_trip = 1'b1;
    @(negedge clk);
    lowv_trip = 1'b0;
    observe(g, p, h);
    check("R8 restart pin cycles", p, 32);
    check("R8 restart hold cycles", h, 64);
    check("R6 R11 status u0", st0, 4'b0010);
    check("R11 status u1 restart", st1, 4'b0111);
  endtask

  task automatic t_lowv;
    int g, p, h;
    repeat (5) @(negedge clk);
    lowv_trip = 1'b1;
    @(negedge clk);
    lowv_trip = 1'b0;
    observe(g, p, h);
    check("R6 pin cycles", p, 32);
    check("R6 hold cycles", h, 64);
    check("R6 status", st0, 4'b0010);
  endtask

  task automatic t_ext;
    int g, p, h;
    repeat (5) @(negedge clk);
    ext_pull = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 hold while pin low", hold0, 1);
    check("R7 no drive on ext", drv0, 0);
    check("R10 status before ext release", st0, 4'b0010);
    ext_pull = 1'b0;
    observe(g, p, h);
    check("R7 hold after pin high", h, 35);
    check("R7 R9 pin not driven", p, 0);
    check("R7 status u0", st0, 4'b1000);
    check("R11 status u1 ext", st1, 4'b1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_poweron();
    t_wdog();
    t_restart();
    t_lowv();
    t_ext();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule